// File: doc/BRIEF.md
# Radio Bit-Serial Byte Buffer with Centre-Aligned Sampling

This block connects a byte-wide processor interface to a half-duplex, bit-serial on/off-keyed radio line. In receive mode it waits for a start indication from an external start-symbol detector. That indication carries the age, in clock cycles, of the captured start edge. The block loads a bit-period down-counter so that its first expiry falls half a bit period after the captured edge, and every later expiry falls one bit period after the one before. Each expiry toggles an internal sample clock and latches the radio line into a shift register. The asynchronous radio signal is therefore read as if it were a clocked serial link. Complete bytes are handed to the processor through a holding register with a ready flag and an overrun flag. The bits of a byte that is still being assembled can be read at any time.

In transmit mode the processor writes bytes into a one-byte holding register. The block shifts each byte onto the line most significant bit first, holding each bit for one bit period. Back-to-back bytes follow with no gap. A one-cycle request pulse asks for the next byte when the final bit of the current byte goes out. A bypass control hands the line to software: the processor drives the transmit line directly and reads the receive level directly. Line coding, framing and back-off are left to software.

The controlling state machine has five states. RX_IDLE waits for a start. RX_RUN samples received bits. TX_IDLE waits for a byte. TX_RUN shifts out bits. BYPASS gives the line to software. The named transitions are:
- start-accept: RX_IDLE to RX_RUN.
- realign: RX_RUN to RX_RUN on a new start.
- to-transmit: RX_IDLE or RX_RUN to TX_IDLE when the mode input selects transmit.
- launch: TX_IDLE to TX_RUN when a byte is held.
- drain: TX_RUN to TX_IDLE after the final bit when no byte is held.
- to-receive: TX_IDLE or TX_RUN to RX_IDLE when the mode input selects receive.
- bypass-enter: any state to BYPASS.
- bypass-exit: BYPASS to RX_IDLE or TX_IDLE, according to the mode input.

Reception continues until the processor leaves receive mode, enters bypass, or raises a new start.

Top module: `radio_bitbuf`

## Requirements
- R1: After reset, tx_line, rx_ready, rx_overrun, tx_full, tx_req, sample_clk and rx_bitcnt are all 0.
- R2: Let half = cfg_period/2. For a start accepted in cycle E+age, where E is the cycle of the captured edge, the first sample is taken in cycle E+half when age < half. When age >= half, the first sample is taken in cycle E+age+1. sample_clk changes one cycle after the sample cycle.
- R3: After the first sample, one sample is taken every cfg_period cycles. sample_clk toggles once per sample and never toggles while no transfer is running.
- R4: Received bits are shifted in so that the first bit received ends up in bit 7 of rx_data. rx_ready rises the cycle after the eighth sample of a byte, and rx_bitcnt returns to 0 at the same time.
- R5: While a byte is being assembled, rx_bitcnt gives the number of bits taken so far (0 to 7). rx_partial holds those bits, with the newest bit in bit 0.
- R6: If a byte completes while rx_ready is still set and rx_rd is not asserted in that cycle, rx_overrun is set and rx_data takes the newer byte. rx_overrun is never set while rx_ready is clear.
- R7: A pulse on rx_rd clears rx_ready and rx_overrun.
- R8: In transmit mode, a byte written in cycle c appears on tx_line from cycle c+2, most significant bit first, with each bit held for cfg_period cycles. When no bit is being sent, tx_line is 0.
- R9: tx_full is set by an accepted write. A write while tx_full is 1 is ignored. A held byte starts directly after the final bit of the current byte, with no idle cycle.
- R10: tx_req is a one-cycle pulse in the first cycle in which bit 0 (the final bit) of a byte is on tx_line.
- R11: Operation is half duplex. In transmit mode, start indications and the receive line leave rx_ready and rx_bitcnt unchanged. In receive mode, tx_line stays 0.
- R12: While cfg_bypass is 1, tx_line equals byp_drive. rx_level always follows rx_line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx_mode | input | 1 | 1 selects transmit, 0 selects receive |
| cfg_bypass | input | 1 | 1 gives the line to software |
| cfg_period | input | TIMER_W | Bit period in clock cycles (at least 4) |
| start_valid | input | 1 | Start-edge indication from the detector |
| start_age | input | TIMER_W | Cycles elapsed since the captured start edge |
| rx_line | input | 1 | Radio receive data |
| rx_rd | input | 1 | Read strobe for the received byte |
| rx_data | output | DATA_W | Last complete received byte |
| rx_ready | output | 1 | A received byte is waiting |
| rx_overrun | output | 1 | A byte was overwritten before it was read |
| rx_partial | output | DATA_W | Bits assembled so far |
| rx_bitcnt | output | $clog2(DATA_W) | Number of bits assembled so far |
| tx_wr | input | 1 | Write strobe for the transmit byte |
| tx_wdata | input | DATA_W | Byte to send |
| tx_full | output | 1 | Transmit holding register occupied |
| tx_req | output | 1 | Next-byte request pulse |
| tx_line | output | 1 | Radio transmit data |
| byp_drive | input | 1 | Line level driven by software in bypass |
| rx_level | output | 1 | Direct view of the receive line |
| sample_clk | output | 1 | Internal bit clock, toggles on every sample |

## Verification
The bench aims at the sampling phase. It measures the exact cycle of the first sample-clock toggle for a fresh start edge, for a late start indication and for one past the half-period clamp. A design that ignores the age, or that does not clamp, would toggle early or late, or wrap round and sample near the end of a bit. It checks the bit-7 request timing and the seamless hand-over between bytes, where an off-by-one design pulses one bit early or inserts an idle gap. It also checks that a write landing while the holding register is full is dropped: a wrong design would put that byte on the line. Finally it checks overrun: two bytes are left unread, and the bench expects the flag and the newer byte. It also stimulates the receive side while transmitting; a design that is not half duplex would change the bit count there.

// File: rtl/radio_bitbuf_pkg.sv
package radio_bitbuf_pkg;

    typedef enum logic [2:0] {
        ST_RX_IDLE = 3'd0,
        ST_RX_RUN  = 3'd1,
        ST_TX_IDLE = 3'd2,
        ST_TX_RUN  = 3'd3,
        ST_BYPASS  = 3'd4
    } link_state_e;

endpackage

// File: rtl/rbb_bit_timer.sv
// Bit-period down-counter; expires once per period and toggles the bit clock.
module rbb_bit_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic [TW-1:0] period,
    output logic          tick,
    output logic          sclk
);
    logic [TW-1:0] cnt_q;

    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else begin
            if (load) begin
                cnt_q <= load_val;
            end else if (tick) begin
                cnt_q <= period - TW'(1);
            end else if (run) begin
                cnt_q <= cnt_q - TW'(1);
            end
            if (tick) begin
                sclk <= ~sclk;
            end
        end
    end
endmodule

// File: rtl/rbb_rx_deser.sv
// Receive shift register with a holding byte, a ready flag and an overrun flag.
module rbb_rx_deser #(
    parameter int DW = 8,
    localparam int CW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          sample,
    input  logic          bit_in,
    input  logic          rd,
    output logic [DW-1:0] data,
    output logic          ready,
    output logic          overrun,
    output logic [DW-1:0] partial,
    output logic [CW-1:0] bitcnt
);
    logic [DW-1:0] shreg_q;
    logic [DW-1:0] shreg_n;
    logic          complete;

    assign shreg_n  = {shreg_q[DW-2:0], bit_in};
    assign complete = sample && !clr && (bitcnt == CW'(DW-1));
    assign partial  = shreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bitcnt  <= '0;
            data    <= '0;
            ready   <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (clr) begin
                shreg_q <= '0;
                bitcnt  <= '0;
            end else if (sample) begin
                shreg_q <= complete ? '0 : shreg_n;
                bitcnt  <= complete ? '0 : bitcnt + CW'(1);
            end
            if (complete) begin
                data    <= shreg_n;
                ready   <= 1'b1;
                overrun <= (ready || overrun) && !rd;
            end else if (rd) begin
                ready   <= 1'b0;
                overrun <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rbb_tx_ser.sv
// Transmit holding register and MSB-first shifter with a next-byte request.
module rbb_tx_ser #(
    parameter int DW = 8,
    localparam int CW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          launch,
    input  logic          bit_tick,
    output logic          full,
    output logic          line_bit,
    output logic          req,
    output logic          drained
);
    logic [DW-1:0] hold_q;
    logic [DW-1:0] shreg_q;
    logic [CW-1:0] idx_q;
    logic          last_bit;
    logic          consume;

    assign last_bit = (idx_q == CW'(DW-1));
    assign consume  = launch || (bit_tick && last_bit && full);
    assign drained  = bit_tick && last_bit && !full;
    assign line_bit = shreg_q[DW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            shreg_q <= '0;
            idx_q   <= '0;
            full    <= 1'b0;
            req     <= 1'b0;
        end else begin
            req <= bit_tick && (idx_q == CW'(DW-2));
            if (wr && !full) begin
                hold_q <= wdata;
                full   <= 1'b1;
            end else if (consume) begin
                full   <= 1'b0;
            end
            if (consume) begin
                shreg_q <= hold_q;
                idx_q   <= '0;
            end else if (bit_tick && !last_bit) begin
                shreg_q <= {shreg_q[DW-2:0], 1'b0};
                idx_q   <= idx_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/radio_bitbuf.sv
module radio_bitbuf
    import radio_bitbuf_pkg::*;
#(
    parameter int TIMER_W = 16,
    parameter int DATA_W  = 8,
    localparam int CNT_W  = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_tx_mode,
    input  logic               cfg_bypass,
    input  logic [TIMER_W-1:0] cfg_period,
    input  logic               start_valid,
    input  logic [TIMER_W-1:0] start_age,
    input  logic               rx_line,
    input  logic               rx_rd,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_ready,
    output logic               rx_overrun,
    output logic [DATA_W-1:0]  rx_partial,
    output logic [CNT_W-1:0]   rx_bitcnt,
    input  logic               tx_wr,
    input  logic [DATA_W-1:0]  tx_wdata,
    output logic               tx_full,
    output logic               tx_req,
    output logic               tx_line,
    input  logic               byp_drive,
    output logic               rx_level,
    output logic               sample_clk
);
    link_state_e        state_q, state_n;
    logic               rx_sel, tx_sel;
    logic               rx_accept, tx_launch;
    logic               timer_load, timer_run, tick;
    logic [TIMER_W-1:0] half_period, align_val, load_val;
    logic               rx_sample, tx_tick;
    logic               ser_bit, ser_drained;

    assign rx_sel      = !cfg_bypass && !cfg_tx_mode;
    assign tx_sel      = !cfg_bypass && cfg_tx_mode;
    assign half_period = cfg_period >> 1;
    assign align_val   = (start_age >= half_period) ? '0
                       : half_period - TIMER_W'(1) - start_age;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RX_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_RX_IDLE: begin
                if (cfg_tx_mode)      state_n = ST_TX_IDLE;
                else if (start_valid) state_n = ST_RX_RUN;
            end
            ST_RX_RUN: begin
                if (cfg_tx_mode)      state_n = ST_TX_IDLE;
            end
            ST_TX_IDLE: begin
                if (!cfg_tx_mode)     state_n = ST_RX_IDLE;
                else if (tx_full)     state_n = ST_TX_RUN;
            end
            ST_TX_RUN: begin
                if (!cfg_tx_mode)     state_n = ST_RX_IDLE;
                else if (ser_drained) state_n = ST_TX_IDLE;
            end
            ST_BYPASS: begin
                state_n = cfg_tx_mode ? ST_TX_IDLE : ST_RX_IDLE;
            end
            default: state_n = ST_RX_IDLE;
        endcase
        if (cfg_bypass) state_n = ST_BYPASS;
    end

    // outputs of the state machine
    always_comb begin
        rx_accept = 1'b0;
        tx_launch = 1'b0;
        timer_run = 1'b0;
        rx_sample = 1'b0;
        tx_tick   = 1'b0;
        tx_line   = 1'b0;
        unique case (state_q)
            ST_RX_IDLE: begin
                rx_accept = rx_sel && start_valid;
            end
            ST_RX_RUN: begin
                rx_accept = rx_sel && start_valid;
                timer_run = 1'b1;
                rx_sample = rx_sel && tick;
            end
            ST_TX_IDLE: begin
                tx_launch = tx_sel && tx_full;
            end
            ST_TX_RUN: begin
                timer_run = 1'b1;
                tx_tick   = tx_sel && tick;
                tx_line   = ser_bit;
            end
            ST_BYPASS: begin
                tx_line   = 1'b0;
            end
            default: begin
                tx_line   = 1'b0;
            end
        endcase
        if (cfg_bypass) tx_line = byp_drive;
    end

    assign timer_load = rx_accept || tx_launch;
    assign load_val   = rx_accept ? align_val : cfg_period - TIMER_W'(1);
    assign rx_level   = rx_line;

    rbb_bit_timer #(.TW(TIMER_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (timer_run),
        .load     (timer_load),
        .load_val (load_val),
        .period   (cfg_period),
        .tick     (tick),
        .sclk     (sample_clk)
    );

    rbb_rx_deser #(.DW(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rx_accept),
        .sample  (rx_sample),
        .bit_in  (rx_line),
        .rd      (rx_rd),
        .data    (rx_data),
        .ready   (rx_ready),
        .overrun (rx_overrun),
        .partial (rx_partial),
        .bitcnt  (rx_bitcnt)
    );

    rbb_tx_ser #(.DW(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (tx_wr),
        .wdata    (tx_wdata),
        .launch   (tx_launch),
        .bit_tick (tx_tick),
        .full     (tx_full),
        .line_bit (ser_bit),
        .req      (tx_req),
        .drained  (ser_drained)
    );
endmodule

// File: rtl/rbb_checker.sv
module rbb_checker #(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_tx_mode,
    input logic          cfg_bypass,
    input logic          byp_drive,
    input logic          tx_line,
    input logic          tx_req,
    input logic          rx_ready,
    input logic          rx_overrun,
    input logic [CW-1:0] rx_bitcnt,
    input logic          sample_clk,
    input logic          timer_run
);
    assert_ovr_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> rx_ready);

    assert_req_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

    assert_sclk_only_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_clk) |-> $past(timer_run));

    assert_ready_resets_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> (rx_bitcnt == '0));

    assert_bypass_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bypass |-> (tx_line == byp_drive));

    assert_rx_mode_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_bypass && !cfg_tx_mode && $past(!cfg_bypass && !cfg_tx_mode)) |-> !tx_line);

    assert_tx_mode_no_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tx_mode && !cfg_bypass && $past(cfg_tx_mode && !cfg_bypass)) |=> $stable(rx_bitcnt));
endmodule

bind radio_bitbuf rbb_checker #(.CW(CNT_W)) u_rbb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_tx_mode (cfg_tx_mode),
    .cfg_bypass  (cfg_bypass),
    .byp_drive   (byp_drive),
    .tx_line     (tx_line),
    .tx_req      (tx_req),
    .rx_ready    (rx_ready),
    .rx_overrun  (rx_overrun),
    .rx_bitcnt   (rx_bitcnt),
    .sample_clk  (sample_clk),
    .timer_run   (timer_run)
);

// File: tb/test_radio_bitbuf.sv
`timescale 1ns/1ps
module test_radio_bitbuf;
    localparam int TW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_tx_mode = 1'b0;
    logic          cfg_bypass = 1'b0;
    logic [TW-1:0] cfg_period = TW'(20);
    logic          start_valid = 1'b0;
    logic [TW-1:0] start_age = '0;
    logic          rx_line = 1'b0;
    logic          rx_rd = 1'b0;
    logic [DW-1:0] rx_data;
    logic          rx_ready;
    logic          rx_overrun;
    logic [DW-1:0] rx_partial;
    logic [2:0]    rx_bitcnt;
    logic          tx_wr = 1'b0;
    logic [DW-1:0] tx_wdata = '0;
    logic          tx_full;
    logic          tx_req;
    logic          tx_line;
    logic          byp_drive = 1'b0;
    logic          rx_level;
    logic          sample_clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [7:0] pkt [0:7];

    always #2.5 clk = ~clk;

    radio_bitbuf #(.TIMER_W(TW), .DATA_W(DW)) i_radio_bitbuf (
        .clk(clk), .rst_n(rst_n), .cfg_tx_mode(cfg_tx_mode), .cfg_bypass(cfg_bypass),
        .cfg_period(cfg_period), .start_valid(start_valid), .start_age(start_age),
        .rx_line(rx_line), .rx_rd(rx_rd), .rx_data(rx_data), .rx_ready(rx_ready),
        .rx_overrun(rx_overrun), .rx_partial(rx_partial), .rx_bitcnt(rx_bitcnt),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_full(tx_full), .tx_req(tx_req),
        .tx_line(tx_line), .byp_drive(byp_drive), .rx_level(rx_level),
        .sample_clk(sample_clk)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic stream_bit(input int b);
        return pkt[b / 8][7 - (b % 8)];
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic enter_mode(input logic tx);
        @(negedge clk);
        cfg_bypass = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cfg_bypass  = 1'b0;
        cfg_tx_mode = tx;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Receive nbytes from pkt; the line edge is at loop cycle 0, start is raised at cycle age.
    task automatic rx_packet(input int p, input int age, input int nbytes, input bit do_read,
                             input bit chk_partial);
        int half = p / 2;
        int exp_first = (age >= half) ? age + 2 : half + 1;
        int got = 0;
        bit seen = 0;
        logic sc0;
        enter_mode(1'b0);
        cfg_period = TW'(p);
        sc0 = sample_clk;
        for (int c = 0; c <= nbytes * 8 * p + p; c++) begin
            @(negedge clk);
            if (!seen && sample_clk !== sc0) begin
                seen = 1;
                chk("R2 first sample cycle", c, exp_first);
            end
            if (seen && c == exp_first + p) chk("R3 toggle per period", sample_clk, sc0);
            if (chk_partial && c == half + 2 * p + 1) begin
                chk("R5 bit count", rx_bitcnt, 3);
                chk("R5 partial bits", rx_partial[2:0], pkt[0][7:5]);
            end
            if (c == p) chk("R11 tx line quiet in rx", tx_line, 0);
            rx_rd = 1'b0;
            if (do_read && rx_ready) begin
                chk("R4 received byte", rx_data, pkt[got]);
                chk("R6 no overrun when read", rx_overrun, 0);
                got++;
                rx_rd = 1'b1;
            end
            rx_line     = (c / p < nbytes * 8) ? stream_bit(c / p) : 1'b0;
            start_valid = (c == age);
            start_age   = TW'(age);
        end
        if (!seen) chk("R2 sample clock never toggled", 0, 1);
        if (do_read) chk("R4 byte count", got, nbytes);
        @(negedge clk);
        rx_rd = 1'b0;
        start_valid = 1'b0;
    endtask

    // Transmit nbytes from pkt; a junk write lands while full and must be dropped.
    task automatic tx_stream(input int p, input int nbytes);
        int k = 1;
        logic [2:0] cnt0;
        logic exp_line, exp_req;
        enter_mode(1'b1);
        cfg_period = TW'(p);
        cnt0 = rx_bitcnt;
        for (int c = 0; c <= nbytes * 8 * p + p + 2; c++) begin
            @(negedge clk);
            if (c >= 2 && (c - 2) / p < nbytes * 8) exp_line = stream_bit((c - 2) / p);
            else exp_line = 1'b0;
            if (c < 2 || (c - 2) % p == 0 || (c - 2) % p == p / 2 || (c - 2) % p == p - 1)
                chk("R8 tx line bit", tx_line, exp_line);
            if (c >= 2 && (c - 2) % p == 0) begin
                exp_req = ((c - 2) / p < nbytes * 8) && (((c - 2) / p) % 8 == 7);
                chk("R10 next-byte request", tx_req, exp_req);
            end
            if (c == 1) chk("R9 full after write", tx_full, 1);
            tx_wr = 1'b0;
            if (c == 0) begin
                tx_wr = 1'b1;
                tx_wdata = pkt[0];
            end else if (c == 1) begin
                tx_wr = 1'b1;
                tx_wdata = ~pkt[0] ^ 8'h5A;
            end else if (!tx_full && k < nbytes) begin
                tx_wr = 1'b1;
                tx_wdata = pkt[k];
                k++;
            end
            rx_line = 1'($urandom);
            start_valid = (c == 5);
            start_age = '0;
        end
        start_valid = 1'b0;
        @(negedge clk);
        chk("R11 no rx byte in tx", rx_ready, 0);
        chk("R11 rx count frozen in tx", rx_bitcnt, cnt0);
        chk("R9 holding empty after drain", tx_full, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4217);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tx_line", tx_line, 0);
        chk("R1 rx_ready", rx_ready, 0);
        chk("R1 rx_overrun", rx_overrun, 0);
        chk("R1 tx_full", tx_full, 0);
        chk("R1 tx_req", tx_req, 0);
        chk("R1 sample_clk", sample_clk, 0);
        chk("R1 rx_bitcnt", rx_bitcnt, 0);

        // directed receive: prompt start, late start, start past the clamp
        pkt[0] = 8'hB4; pkt[1] = 8'h0F; pkt[2] = 8'hC3;
        rx_packet(20, 0, 3, 1, 1);
        rx_packet(20, 7, 2, 1, 1);
        rx_packet(20, 12, 1, 1, 0);

        // overrun: two bytes left unread
        pkt[0] = 8'h96; pkt[1] = 8'h3C;
        rx_packet(16, 2, 2, 0, 0);
        enter_mode(1'b0);
        chk("R6 ready held", rx_ready, 1);
        chk("R6 overrun set", rx_overrun, 1);
        chk("R6 newer byte kept", rx_data, 8'h3C);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        chk("R7 read clears ready", rx_ready, 0);
        chk("R7 read clears overrun", rx_overrun, 0);

        // directed transmit
        pkt[0] = 8'h81; pkt[1] = 8'h7E; pkt[2] = 8'h55;
        tx_stream(12, 3);

        // bypass
        @(negedge clk);
        cfg_bypass = 1'b1;
        for (int i = 0; i < 6; i++) begin
            byp_drive = 1'($urandom);
            rx_line   = 1'($urandom);
            @(negedge clk);
            chk("R12 bypass drive", tx_line, byp_drive);
            chk("R12 line readback", rx_level, rx_line);
        end
        cfg_bypass = 1'b0;

        // random mix
        for (int t = 0; t < 6; t++) begin
            int p = 8 + 2 * int'($urandom % 17);
            int nb = 1 + int'($urandom % 4);
            for (int b = 0; b < 8; b++) pkt[b] = 8'($urandom);
            rx_packet(p, int'($urandom % (p / 2)), nb, 1, 1);
        end
        for (int t = 0; t < 4; t++) begin
            int p = 8 + 2 * int'($urandom % 13);
            int nb = 1 + int'($urandom % 3);
            for (int b = 0; b < 8; b++) pkt[b] = 8'($urandom);
            tx_stream(p, nb);
        end

        finish_run();
    end
endmodule